// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one starting column address into the full series of column addresses for a burst access. A small mode register holds the burst length and the ordering. Serial ordering counts upward and wraps inside the aligned group of columns the burst covers. Interleave ordering XORs the start address with the beat number. Only the low address bits that the burst length covers ever change. The higher bits keep the start value for the whole burst.

A start strobe loads the starting column and a read/write flag. On each following clock the block presents one column address with a valid flag and a last-beat flag. It also drives an output-enable that is high only during read beats, so the data pins float once a read burst ends. A new strobe may follow the last beat with no gap. A strobe that arrives in the middle of a burst abandons that burst and starts over from the new address.

Top module: `burst_col_seq`

## Requirements
- R1: On the clock after a cycle with `start` high, `col_valid` is 1 and `col_addr` equals the `start_col` sampled with the strobe.
- R2: The mode length code selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. `col_last` is high on the final beat only. If no new strobe arrives, `col_valid` is 0 on the following cycle.
- R3: With the order bit at 0 (serial), beat k has low bits equal to (start + k) modulo the burst length, taken within the aligned group. For example, start 1 with length 4 gives 1, 2, 3, 0.
- R4: With the order bit at 1 (interleave), beat k has low bits equal to the start XOR k. Start 1 with length 4 gives 1, 0, 3, 2. Start 3 gives 3, 2, 1, 0. With length 2, both orders give the same sequence.
- R5: Address bits at or above bit log2(length) keep the start value on every beat of a burst.
- R6: With length 1, the single beat carries the start address and has `col_last` high.
- R7: `dq_oe` is high exactly on the valid beats of a burst started with `start_rd`=1. It is low for write bursts and low from the cycle after a read burst's last beat until the next read begins.
- R8: A strobe during the last beat starts the next burst on the very next cycle, with no idle cycle between the bursts.
- R9: A strobe during a burst ends that burst at once and restarts from the new address, with the beat count starting from zero.
- R10: A `mode_we` pulse takes effect only when no burst is active and `start` is low. A write attempted during a burst, or in the same cycle as a strobe, leaves the length and order unchanged.
- R11: While reset is asserted, `col_valid`, `col_last` and `dq_oe` are 0. The mode register resets to length 1 in serial order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_len | input | 2 | Length code to write (0:1, 1:2, 2:4, 3:8) |
| mode_ilv | input | 1 | Order to write (0 serial, 1 interleave) |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Starting column address |
| start_rd | input | 1 | 1 for a read burst, 0 for a write burst |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | A burst beat is presented |
| col_last | output | 1 | Final beat of the burst |
| dq_oe | output | 1 | Read data may drive the bus |

## Verification
Start values at 1 and 3 in a 4-beat burst tell serial wrap apart from interleave, because the two orders give different sequences for these starts. The 2-beat runs show that both orders then agree. An 8-beat start with nonzero upper bits separates a correct 3-bit wrap from a carry that leaks into the upper bits, and a start near the top of the column range shows the same for interleave order. Back-to-back strobes, mid-burst strobes, and mode writes made during a burst or in a strobe cycle separate a correct restart and write guard from a sequencer that drops a cycle or takes a new length mid-burst. Write bursts and read bursts with the same addresses isolate the output-enable.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [1:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_rd,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             dq_oe
);
  localparam int LW = 3;

  logic [1:0]       len_q;
  logic             ilv_q;
  logic             active_q;
  logic             rd_q;
  logic [COL_W-1:0] base_q;
  logic [LW-1:0]    beat_q;

  logic [LW-1:0] mask, low_ser, low_ilv, low_b;
  logic          at_end;

  assign mask    = LW'((4'd1 << len_q) - 4'd1);
  assign at_end  = (beat_q == mask);
  assign low_b   = base_q[LW-1:0];
  assign low_ser = (low_b & ~mask) | ((low_b + beat_q) & mask);
  assign low_ilv = low_b ^ beat_q;

  assign col_addr  = {base_q[COL_W-1:LW], ilv_q ? low_ilv : low_ser};
  assign col_valid = active_q;
  assign col_last  = active_q && at_end;
  assign dq_oe     = active_q && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= 2'd0;
      ilv_q <= 1'b0;
    end else if (mode_we && !active_q && !start) begin
      len_q <= mode_len;
      ilv_q <= mode_ilv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      rd_q     <= start_rd;
      base_q   <= start_col;
      beat_q   <= '0;
    end else if (active_q) begin
      if (at_end) begin
        active_q <= 1'b0;
        rd_q     <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             dq_oe,
  input logic             busy,
  input logic [2:0]       mode_now
);
  assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> col_valid && col_addr == $past(start_col));

  assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  assert_burst_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start) |=>
      col_valid && col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]));

  assert_oe_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> col_valid);

  assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || start) |=> $stable(mode_now));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
  .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
  .dq_oe(dq_oe), .busy(active_q), .mode_now({len_q, ilv_q})
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  logic clk = 0, rst_n = 0;
  logic mode_we = 0, mode_ilv = 0, start = 0, start_rd = 0;
  logic [1:0] mode_len = 0;
  logic [COL_W-1:0] start_col = 0;
  logic [COL_W-1:0] col_addr;
  logic col_valid, col_last, dq_oe;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (.*);

  typedef struct {
    logic v; logic [COL_W-1:0] a; logic l; logic o; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_len = 1; bit m_ilv = 0, m_act = 0, m_rd = 0;
  int m_base = 0, m_k = 0;

  function automatic int ref_addr();
    int lo = m_base % m_len;
    int grp = m_base - lo;
    if (m_ilv) return m_base ^ m_k;
    return grp + ((lo + m_k) % m_len);
  endfunction

  task automatic step(input bit st, input int col, input bit rd,
                      input bit we, input int lcode, input bit ilv, input string tag);
    exp_t e;
    @(negedge clk);
    start = st; start_col = COL_W'(col); start_rd = rd;
    mode_we = we; mode_len = 2'(lcode); mode_ilv = ilv;
    if (we && !m_act && !st) begin m_len = 1 << lcode; m_ilv = ilv; end
    if (st) begin m_act = 1; m_base = col; m_k = 0; m_rd = rd; end
    else if (m_act) begin
      if (m_k == m_len - 1) begin m_act = 0; m_rd = 0; end
      else m_k++;
    end
    e.v = m_act;
    e.a = m_act ? COL_W'(ref_addr()) : '0;
    e.l = m_act && (m_k == m_len - 1);
    e.o = m_act && m_rd;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic set_mode(input int lcode, input bit ilv, input string tag);
    step(0, 0, 0, 1, lcode, ilv, tag);
  endtask

  task automatic burst(input int col, input bit rd, input string tag);
    step(1, col, rd, 0, 0, 0, tag);
    idle(m_len, tag);
  endtask

  // monitor
  always begin
    exp_t e;
    @(posedge clk); #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (col_valid !== e.v || col_last !== e.l || dq_oe !== e.o ||
          (e.v && col_addr !== e.a)) begin
        errors++;
        $display("FAIL %s: got v=%b a=%0d l=%b oe=%b, expected v=%b a=%0d l=%b oe=%b",
                 e.tag, col_valid, col_addr, col_last, dq_oe, e.v, e.a, e.l, e.o);
      end
    end
  end

  initial begin
    #12;
    checks++;
    if (col_valid !== 0 || col_last !== 0 || dq_oe !== 0) begin
      errors++;
      $display("FAIL R11 reset: got v=%b l=%b oe=%b, expected 0 0 0",
               col_valid, col_last, dq_oe);
    end
    @(negedge clk); rst_n = 1;
    // R11/R6: reset mode is length 1 serial
    burst(37, 1, "R11 reset mode");
    set_mode(2, 0, "R3");
    burst(1, 1, "R3 serial start1");
    burst(6, 0, "R3 serial start6 write R7");
    set_mode(2, 1, "R4");
    burst(1, 1, "R4 ilv start1");
    burst(3, 1, "R4 ilv start3");
    set_mode(1, 0, "R2");
    burst(5, 1, "R2 len2 serial");
    set_mode(1, 1, "R2");
    burst(5, 1, "R4 len2 ilv");
    set_mode(3, 0, "R5");
    burst(45, 1, "R5 len8 serial");
    set_mode(3, 1, "R5");
    burst(1022, 0, "R5 len8 ilv");
    set_mode(0, 0, "R6");
    burst(9, 1, "R6 len1 read");
    burst(10, 0, "R6 len1 write R7");
    // R8 back-to-back
    set_mode(2, 0, "R8");
    step(1, 2, 1, 0, 0, 0, "R8 first");
    idle(3, "R8 first");
    step(1, 12, 0, 0, 0, 0, "R8 second");
    idle(4, "R8 second");
    // R9 restart mid-burst
    set_mode(3, 0, "R9");
    step(1, 100, 1, 0, 0, 0, "R9 first");
    idle(2, "R9 first");
    step(1, 203, 0, 0, 0, 0, "R9 restart");
    idle(8, "R9 restart");
    // R10 write during burst ignored
    set_mode(2, 1, "R10");
    step(1, 7, 1, 0, 0, 0, "R10 busy");
    step(0, 0, 0, 1, 3, 0, "R10 busy write");
    idle(3, "R10 busy");
    burst(7, 1, "R10 keeps len4 ilv");
    step(1, 1, 1, 1, 0, 0, "R10 write with start");
    idle(4, "R10 write with start");
    burst(2, 0, "R10 mode still len4 ilv");
    idle(3, "R2 idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule